// File: doc/BRIEF.md
# Reset and Power-Down Abort Sequencer

This block is the control logic that decides how a flash-style memory reacts to its active-low reset/power-down pin. It samples the pin and the busy flag of the program/erase engine on every clock. A low pulse that lasts long enough moves the device out of normal operation. If the engine is idle, the device drops into deep power-down. If the engine is busy, the operation is aborted and the device passes through a timed shutdown.

During an abort the block emits a one-cycle pulse with the address of the interrupted operation, so that the array manager can mark that location or block as invalid. When the shutdown interval ends, the pin level at that moment chooses the next mode. A pin that is already high leads to read-array mode. A pin that is still low leads to deep power-down. On any return to operation, the status register is forced to 0x80. Reads and writes are then held off by two separate wake-up counters. After an abort, those counters start at the end of the shutdown interval, not at the pin's rising edge.

All intervals are parameters counted in clock cycles. The program/erase algorithms and the array itself live elsewhere.

Top module: `abort_seq_top`

## Requirements
- R1: A low level on `pinRstN` that lasts fewer than `MIN_LOW` consecutive sampled clock edges is ignored. The mode, the ready flags, the status register and `abortPulse` are all unchanged by it, including while the engine is busy and during wake-up.
- R2: `mode` uses this encoding: 2'd0 is read-array (this includes wake-up), 2'd1 is shutdown, and 2'd2 is deep power-down. If `pinRstN` is sampled low at `MIN_LOW` consecutive edges while `busy` is low, `mode` is 2'd2 right after the `MIN_LOW`-th edge. Both ready flags are low in deep power-down.
- R3: If the qualifying edge finds `busy` high, `abortPulse` is high for exactly one cycle, namely the first shutdown cycle. In that cycle `abortAddr` equals the `opAddr` that was sampled at the qualifying edge.
- R4: Shutdown (mode 2'd1) lasts exactly `SHUT_CYC` cycles. The pin level during that interval has no effect, except at its final edge.
- R5: At the final shutdown edge, a high pin starts wake-up in read-array mode and a low pin enters deep power-down.
- R6: Deep power-down is held while the pin is low. The first edge that samples the pin high starts wake-up.
- R7: On reset and on every entry to wake-up, `statusReg` is 0x80, and it holds that value through wake-up. In normal read-array operation it takes `engStatus` one cycle later.
- R8: After wake-up starts, `readReady` stays low for `READ_WAKE` cycles and `writeReady` stays low for `WRITE_WAKE` cycles. After an abort these counts begin at the end of the shutdown interval.
- R9: A qualifying reset during wake-up restarts the whole sequence.
- R10: `writeReady` is never high while `readReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| sysRstN | input | 1 | Asynchronous active-low reset of the sequencer itself |
| pinRstN | input | 1 | Active-low reset/power-down pin, synchronous to clk |
| busy | input | 1 | Program/erase engine is running |
| opAddr | input | ADDR_W | Address of the running program/erase operation |
| engStatus | input | 8 | Status byte from the engine during normal operation |
| mode | output | 2 | 0 read-array, 1 shutdown, 2 deep power-down |
| statusReg | output | 8 | Status register value |
| readReady | output | 1 | Reads are valid |
| writeReady | output | 1 | Writes are accepted |
| abortPulse | output | 1 | One-cycle abort marker |
| abortAddr | output | ADDR_W | Address to flag as invalid |

## Verification
The bench builds the block with MIN_LOW=3, SHUT_CYC=5, READ_WAKE=2 and WRITE_WAKE=6. With these values, a pulse of exactly MIN_LOW-1 cycles and one of exactly MIN_LOW cycles can be driven side by side. The pin can also be released at the shutdown's last edge or one edge later, which makes both branches of the end-of-shutdown decision reachable in a few cycles. The gap between the two wake-up counts is wide enough to show the state where reads are ready but writes are not, and to start a new reset inside it.

// File: rtl/abort_seq_pkg.sv
package abort_seq_pkg;

  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_SHUT  = 2'd2,
    ST_PDOWN = 2'd3
  } seqState_e;

  localparam logic [1:0] MODE_READ  = 2'd0;
  localparam logic [1:0] MODE_SHUT  = 2'd1;
  localparam logic [1:0] MODE_PDOWN = 2'd2;

  localparam logic [7:0] STATUS_READY = 8'h80;

  typedef struct packed {
    logic incLow;
    logic incShut;
    logic clrShut;
    logic incWake;
    logic clrWake;
    logic loadStat;
    logic presetStat;
    logic captAbort;
  } seqStrobe_t;

endpackage

// File: rtl/abort_seq_dp.sv
module abort_seq_dp
  import abort_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MIN_LOW    = 4,
  parameter int SHUT_CYC   = 8,
  parameter int READ_WAKE  = 3,
  parameter int WRITE_WAKE = 6
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        engStatus,
  output logic              lowDone,
  output logic              shutDone,
  output logic              wakeDone,
  output logic              readWakeOk,
  output logic [7:0]        statusReg,
  output logic              abortPulse,
  output logic [ADDR_W-1:0] abortAddr
);

  localparam int LOW_W  = $clog2(MIN_LOW + 1);
  localparam int SHUT_W = $clog2(SHUT_CYC + 1);
  localparam int WAKE_W = $clog2(WRITE_WAKE + 1);

  localparam logic [LOW_W-1:0]  LOW_LAST   = LOW_W'(MIN_LOW - 1);
  localparam logic [SHUT_W-1:0] SHUT_LAST  = SHUT_W'(SHUT_CYC - 1);
  localparam logic [WAKE_W-1:0] WAKE_LAST  = WAKE_W'(WRITE_WAKE - 1);
  localparam logic [WAKE_W-1:0] WAKE_RDOK  = WAKE_W'(READ_WAKE);
  localparam logic [WAKE_W-1:0] WAKE_TOP   = WAKE_W'(WRITE_WAKE);

  logic [LOW_W-1:0]  lowCnt;
  logic [SHUT_W-1:0] shutCnt;
  logic [WAKE_W-1:0] wakeCnt;

  // consecutive low-sample run; any high sample or other state clears it
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)        lowCnt <= '0;
    else if (stb.incLow) lowCnt <= lowCnt + 1'b1;
    else                 lowCnt <= '0;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)         shutCnt <= '0;
    else if (stb.clrShut) shutCnt <= '0;
    else if (stb.incShut) shutCnt <= shutCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)                              wakeCnt <= '0;
    else if (stb.clrWake)                      wakeCnt <= '0;
    else if (stb.incWake && wakeCnt != WAKE_TOP) wakeCnt <= wakeCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)            statusReg <= STATUS_READY;
    else if (stb.presetStat) statusReg <= STATUS_READY;
    else if (stb.loadStat)   statusReg <= engStatus;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      abortPulse <= 1'b0;
      abortAddr  <= '0;
    end else begin
      abortPulse <= stb.captAbort;
      if (stb.captAbort) abortAddr <= opAddr;
    end
  end

  assign lowDone    = (lowCnt == LOW_LAST);
  assign shutDone   = (shutCnt == SHUT_LAST);
  assign wakeDone   = (wakeCnt == WAKE_LAST);
  assign readWakeOk = (wakeCnt >= WAKE_RDOK);

endmodule

// File: rtl/abort_seq_ctrl.sv
module abort_seq_ctrl
  import abort_seq_pkg::*;
(
  input  logic       clk,
  input  logic       sysRstN,
  input  logic       pinRstN,
  input  logic       busy,
  input  logic       lowDone,
  input  logic       shutDone,
  input  logic       wakeDone,
  input  logic       readWakeOk,
  output seqStrobe_t stb,
  output logic [1:0] mode,
  output logic       readReady,
  output logic       writeReady
);

  seqState_e state, nextState;
  logic      operating;
  logic      qualify;

  assign operating = (state == ST_READ) || (state == ST_WAKE);
  assign qualify   = operating && !pinRstN && lowDone;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) state <= ST_READ;
    else          state <= nextState;
  end

  always_comb begin
    nextState  = state;
    stb        = '0;
    stb.incLow = operating && !pinRstN;
    unique case (state)
      ST_READ, ST_WAKE: begin
        if (state == ST_READ) stb.loadStat = 1'b1;
        else                  stb.incWake  = 1'b1;
        if (qualify) begin
          if (busy) begin
            nextState     = ST_SHUT;
            stb.clrShut   = 1'b1;
            stb.captAbort = 1'b1;
          end else begin
            nextState = ST_PDOWN;
          end
        end else if (state == ST_WAKE && wakeDone) begin
          nextState = ST_READ;
        end
      end
      ST_SHUT: begin
        stb.incShut = 1'b1;
        if (shutDone) begin
          if (pinRstN) begin
            nextState      = ST_WAKE;
            stb.clrWake    = 1'b1;
            stb.presetStat = 1'b1;
          end else begin
            nextState = ST_PDOWN;
          end
        end
      end
      ST_PDOWN: begin
        if (pinRstN) begin
          nextState      = ST_WAKE;
          stb.clrWake    = 1'b1;
          stb.presetStat = 1'b1;
        end
      end
      default: nextState = ST_READ;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_SHUT:  mode = MODE_SHUT;
      ST_PDOWN: mode = MODE_PDOWN;
      default:  mode = MODE_READ;
    endcase
  end

  assign readReady  = (state == ST_READ) || (state == ST_WAKE && readWakeOk);
  assign writeReady = (state == ST_READ);

endmodule

// File: rtl/abort_seq_top.sv
module abort_seq_top
  import abort_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MIN_LOW    = 4,
  parameter int SHUT_CYC   = 8,
  parameter int READ_WAKE  = 3,
  parameter int WRITE_WAKE = 6
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              pinRstN,
  input  logic              busy,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        engStatus,
  output logic [1:0]        mode,
  output logic [7:0]        statusReg,
  output logic              readReady,
  output logic              writeReady,
  output logic              abortPulse,
  output logic [ADDR_W-1:0] abortAddr
);

  seqStrobe_t stb;
  logic lowDone, shutDone, wakeDone, readWakeOk;

  abort_seq_ctrl uCtrl (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .pinRstN    (pinRstN),
    .busy       (busy),
    .lowDone    (lowDone),
    .shutDone   (shutDone),
    .wakeDone   (wakeDone),
    .readWakeOk (readWakeOk),
    .stb        (stb),
    .mode       (mode),
    .readReady  (readReady),
    .writeReady (writeReady)
  );

  abort_seq_dp #(
    .ADDR_W     (ADDR_W),
    .MIN_LOW    (MIN_LOW),
    .SHUT_CYC   (SHUT_CYC),
    .READ_WAKE  (READ_WAKE),
    .WRITE_WAKE (WRITE_WAKE)
  ) uDp (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .stb        (stb),
    .opAddr     (opAddr),
    .engStatus  (engStatus),
    .lowDone    (lowDone),
    .shutDone   (shutDone),
    .wakeDone   (wakeDone),
    .readWakeOk (readWakeOk),
    .statusReg  (statusReg),
    .abortPulse (abortPulse),
    .abortAddr  (abortAddr)
  );

endmodule

// File: rtl/abort_seq_chk.sv
module abort_seq_chk #(
  parameter int SHUT_CYC = 8
) (
  input logic       clk,
  input logic       sysRstN,
  input logic       pinRstN,
  input logic [1:0] mode,
  input logic [7:0] statusReg,
  input logic       readReady,
  input logic       writeReady,
  input logic       abortPulse
);

  int shutRun;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)          shutRun <= 0;
    else if (mode == 2'd1) shutRun <= shutRun + 1;
    else                   shutRun <= 0;
  end

  // R3
  abort_single_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    abortPulse |=> !abortPulse);

  // R3
  abort_in_shut_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    abortPulse |-> (mode == 2'd1 && $past(mode) != 2'd1));

  // R2
  pdown_quiet_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (mode == 2'd2) |-> (!readReady && !writeReady));

  // R10
  ready_order_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    writeReady |-> readReady);

  // R4
  shut_not_long_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (mode == 2'd1) |-> (shutRun < SHUT_CYC));

  // R4
  shut_full_len_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (mode != 2'd1 && shutRun != 0) |-> (shutRun == SHUT_CYC));

  // R7
  wake_status_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    (mode == 2'd0 && !readReady) |-> (statusReg == 8'h80));

  // R5
  shut_exit_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    ($past(mode) == 2'd1 && mode == 2'd0) |-> !readReady);

  // R6
  pdown_exit_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    ($past(mode) == 2'd2 && $past(pinRstN)) |-> (mode == 2'd0));

endmodule

bind abort_seq_top abort_seq_chk #(.SHUT_CYC(SHUT_CYC)) uChk (
  .clk        (clk),
  .sysRstN    (sysRstN),
  .pinRstN    (pinRstN),
  .mode       (mode),
  .statusReg  (statusReg),
  .readReady  (readReady),
  .writeReady (writeReady),
  .abortPulse (abortPulse)
);

// File: tb/sim_abort_seq_top.sv
`timescale 1ns/1ps
module sim_abort_seq_top;

  localparam int AW = 12;
  localparam int ML = 3;
  localparam int SC = 5;
  localparam int RW = 2;
  localparam int WW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          sysRstN, pinRstN, busy;
  logic [AW-1:0] opAddr, abortAddr;
  logic [7:0]    engStatus, statusReg;
  logic [1:0]    mode;
  logic          readReady, writeReady, abortPulse;

  abort_seq_top #(
    .ADDR_W(AW), .MIN_LOW(ML), .SHUT_CYC(SC), .READ_WAKE(RW), .WRITE_WAKE(WW)
  ) u0 (
    .clk(clk), .sysRstN(sysRstN), .pinRstN(pinRstN), .busy(busy),
    .opAddr(opAddr), .engStatus(engStatus), .mode(mode), .statusReg(statusReg),
    .readReady(readReady), .writeReady(writeReady),
    .abortPulse(abortPulse), .abortAddr(abortAddr)
  );

  int nRun = 0;
  int nFail = 0;
  bit checkOn = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 read, 1 wake, 2 shutdown, 3 power-down
  int            mSt, lowRun, shutEl, wakeEl;
  bit            hit;
  logic [7:0]    mStat;
  logic          mAbort;
  logic [AW-1:0] mAddr;

  always @(posedge clk) begin
    if (!sysRstN) begin
      mSt = 0; lowRun = 0; shutEl = 0; wakeEl = 0;
      mStat = 8'h80; mAbort = 0; mAddr = '0;
    end else begin
      mAbort = 0;
      hit = 0;
      case (mSt)
        0, 1: begin
          if (mSt == 0) mStat = engStatus;
          else          wakeEl++;
          if (!pinRstN) begin
            lowRun++;
            if (lowRun >= ML) begin hit = 1; lowRun = 0; end
          end else lowRun = 0;
          if (hit) begin
            if (busy) begin mSt = 2; shutEl = 0; mAbort = 1; mAddr = opAddr; end
            else mSt = 3;
          end else if (mSt == 1 && wakeEl == WW) mSt = 0;
        end
        2: begin
          lowRun = 0;
          shutEl++;
          if (shutEl == SC) begin
            if (pinRstN) begin mSt = 1; wakeEl = 0; mStat = 8'h80; end
            else mSt = 3;
          end
        end
        default: begin
          lowRun = 0;
          if (pinRstN) begin mSt = 1; wakeEl = 0; mStat = 8'h80; end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (checkOn) begin
      chk("R2 mode", 32'(mode), (mSt <= 1) ? 32'd0 : (mSt == 2) ? 32'd1 : 32'd2);
      chk("R3 abortPulse", 32'(abortPulse), 32'(mAbort));
      if (mAbort) chk("R3 abortAddr", 32'(abortAddr), 32'(mAddr));
      chk("R7 statusReg", 32'(statusReg), 32'(mStat));
      chk("R8 readReady", 32'(readReady), 32'(mSt == 0 || (mSt == 1 && wakeEl >= RW)));
      chk("R8 writeReady", 32'(writeReady), 32'(mSt == 0));
      chk("R10 ready order", 32'(writeReady & ~readReady), 32'd0);
    end
  end

  initial begin
    sysRstN = 0; pinRstN = 1; busy = 0; opAddr = '0; engStatus = 8'h00;
    repeat (3) @(negedge clk);
    chk("R7 reset status", 32'(statusReg), 32'h80);
    chk("R2 reset mode", 32'(mode), 32'd0);
    chk("R3 reset abort", 32'(abortPulse), 32'd0);
    sysRstN = 1;
    checkOn = 1;
    engStatus = 8'h5A;
    @(negedge clk);
    chk("R7 status follows engine", 32'(statusReg), 32'h5A);

    // R1: short pulse, idle then busy
    pinRstN = 0; repeat (ML - 1) @(negedge clk); pinRstN = 1;
    @(negedge clk);
    chk("R1 short idle mode", 32'(mode), 32'd0);
    chk("R1 short idle ready", 32'({readReady, writeReady}), 32'd3);
    chk("R1 short idle status", 32'(statusReg), 32'h5A);
    busy = 1; opAddr = 12'h111;
    pinRstN = 0; repeat (ML - 1) @(negedge clk); pinRstN = 1;
    @(negedge clk);
    chk("R1 short busy abort", 32'(abortPulse), 32'd0);
    chk("R1 short busy mode", 32'(mode), 32'd0);
    busy = 0;

    // R2 / R6 / R8: idle power-down and wake-up timing
    pinRstN = 0; repeat (ML) @(negedge clk);
    chk("R2 pdown mode", 32'(mode), 32'd2);
    chk("R2 pdown ready", 32'(readReady), 32'd0);
    repeat (4) @(negedge clk);
    chk("R6 pdown held", 32'(mode), 32'd2);
    pinRstN = 1; @(negedge clk);
    chk("R6 pdown exit", 32'(mode), 32'd0);
    chk("R8 read held", 32'(readReady), 32'd0);
    chk("R7 wake status", 32'(statusReg), 32'h80);
    repeat (RW) @(negedge clk);
    chk("R8 read ready", 32'(readReady), 32'd1);
    chk("R8 write still held", 32'(writeReady), 32'd0);
    repeat (WW - RW - 1) @(negedge clk);
    chk("R8 write held last", 32'(writeReady), 32'd0);
    @(negedge clk);
    chk("R8 write ready", 32'(writeReady), 32'd1);
    @(negedge clk);
    chk("R7 status reload", 32'(statusReg), 32'h5A);

    // R3 / R4 / R5: abort, pin released early
    busy = 1; opAddr = 12'hABC;
    pinRstN = 0; repeat (ML) @(negedge clk);
    chk("R3 abort mode", 32'(mode), 32'd1);
    chk("R3 abort pulse", 32'(abortPulse), 32'd1);
    chk("R3 abort addr", 32'(abortAddr), 32'hABC);
    pinRstN = 1; busy = 0; opAddr = '0;
    @(negedge clk);
    chk("R3 pulse one cycle", 32'(abortPulse), 32'd0);
    repeat (SC - 2) @(negedge clk);
    chk("R4 shutdown still", 32'(mode), 32'd1);
    @(negedge clk);
    chk("R5 exit to read", 32'(mode), 32'd0);
    chk("R5 exit not ready", 32'(readReady), 32'd0);
    repeat (RW) @(negedge clk);
    chk("R8 read from shut end", 32'(readReady), 32'd1);
    repeat (WW - RW) @(negedge clk);
    chk("R8 write from shut end", 32'(writeReady), 32'd1);

    // R4 / R5: release exactly at last shutdown edge
    engStatus = 8'h3C;
    busy = 1; opAddr = 12'h0F0;
    pinRstN = 0; repeat (ML + SC - 1) @(negedge clk);
    chk("R4 boundary still shut", 32'(mode), 32'd1);
    pinRstN = 1; busy = 0;
    @(negedge clk);
    chk("R5 boundary release", 32'(mode), 32'd0);
    repeat (WW + 1) @(negedge clk);
    chk("R7 new engine status", 32'(statusReg), 32'h3C);

    // R5 / R6: pin still low at end of shutdown
    busy = 1; opAddr = 12'h555;
    pinRstN = 0; repeat (ML + SC) @(negedge clk);
    chk("R5 low at end", 32'(mode), 32'd2);
    busy = 0;
    repeat (3) @(negedge clk);
    pinRstN = 1; @(negedge clk);
    chk("R6 exit after abort", 32'(mode), 32'd0);

    // R9: qualifying reset during wake-up
    @(negedge clk);
    pinRstN = 0; repeat (ML) @(negedge clk);
    chk("R9 restart pdown", 32'(mode), 32'd2);
    chk("R9 restart ready", 32'(readReady), 32'd0);
    pinRstN = 1; @(negedge clk);
    chk("R9 restart wake", 32'(mode), 32'd0);
    repeat (WW) @(negedge clk);
    chk("R9 write after restart", 32'(writeReady), 32'd1);

    // R1: short pulse inside wake-up leaves counting alone
    pinRstN = 0; repeat (ML) @(negedge clk);
    pinRstN = 1; @(negedge clk);
    pinRstN = 0; repeat (ML - 1) @(negedge clk);
    pinRstN = 1;
    chk("R1 wake short mode", 32'(mode), 32'd0);
    chk("R1 wake short read", 32'(readReady), 32'd1);
    repeat (WW - RW) @(negedge clk);
    chk("R1 wake short write", 32'(writeReady), 32'd1);

    repeat (5) @(negedge clk);
    done = 1;
    checkOn = 0;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule